// File: doc/BRIEF.md
# Per-Core Compare-Value Timer

This block is one core's timer. It owns a shared 64-bit up-count that starts at reset and advances at a programmable rate. It also holds a 64-bit limit. When the count has reached the limit and the timer is enabled, the block raises a level interrupt toward the interrupt controller. Software programs the limit through either of two views of the same storage:
- an absolute compare value;
- a signed 32-bit relative value that is added to the live count.

A three-bit control word holds enable, mask and a read-only status flag.

The rate register holds a tick frequency in Hz. An internal phase accumulator turns the core clock, `CLK_HZ`, into count ticks at that frequency. While the rate register holds zero, the count is stopped and reads as zero.

A small state machine tracks the timer. It has three states:
- **OFF**: enable is clear.
- **ARMED**: enable is set and the count is below the limit.
- **FIRED**: enable is set and the count is at or above the limit.

It moves between these states through three named transitions:
- **arm** (OFF to ARMED or FIRED) when enable is set.
- **expire** (ARMED to FIRED) when the count reaches the limit.
- **rearm** (FIRED to ARMED) when the limit is moved above the count.

Clearing enable takes the timer from any state back to OFF.

Top module: `cmp_timer_top`

## Requirements
- R1: After reset:
  - the control word reads 0;
  - the compare value reads 0;
  - the rate register reads 0x01800000;
  - `irq_o` is low.
- R2: Address 0 is the control word. Bit 0 is enable, bit 1 is mask and bit 2 is status. Writes to status and to bits 63:3 are ignored, and those upper bits read as zero.
- R3: Address 1 is the 64-bit compare value. A write stores all 64 bits, and a read returns them unchanged.
- R4: A read of address 2 returns (compare − count) truncated to 32 bits and zero-extended.
- R5: A write to address 2 sets compare = count + the sign-extended low 32 bits of the write data. The upper data bits are ignored.
- R6: Status is set one clock edge after the registered state shows enable = 1 and count ≥ compare, including count = compare. Status reads 0 whenever enable is 0.
- R7: `irq_o` is high exactly when enable = 1, mask = 0 and status = 1. It falls at the same edge as a control write that sets mask or clears enable.
- R8: While the rate register (address 3) is zero, `count_o` reads zero.
- R9: With rate F ≤ `CLK_HZ`, the count advances F/`CLK_HZ` times per clock on average. With F = `CLK_HZ` it advances every clock; with F = `CLK_HZ`/4 it advances exactly twice in any 8 clocks.
- R10: Address 3 is the 32-bit rate register. It reads back what was written, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 compare, 2 relative, 3 rate |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Combinational read data for `reg_addr_i` |
| count_o | output | 64 | Shared system count |
| irq_o | output | 1 | Level interrupt toward the interrupt controller |

## Verification
Register contents and all read views appear at the first clock edge after the write strobe. The bench samples them on the falling edge that follows that edge.

Status and `irq_o` after an enable or a limit change lag by one further edge, because the state register compares registered values. The bench therefore waits one extra falling edge before it expects the interrupt. Masking and disabling take effect at the write edge itself, so those checks are made on the very next falling edge.

The count is checked as a difference over eight falling edges, never as an absolute value. Relative-programming scenarios wait well before and well after the expected expiry edge.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    typedef enum logic [1:0] {
        TMR_OFF   = 2'd0,
        TMR_ARMED = 2'd1,
        TMR_FIRED = 2'd2
    } tmr_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_TVAL = 2'd2;
    localparam logic [1:0] ADDR_FREQ = 2'd3;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MASK_BIT = 1;

endpackage

// File: rtl/cmp_sys_count.sv
module cmp_sys_count #(
    parameter int              CNT_W    = 64,
    parameter int              FREQ_W   = 32,
    parameter longint unsigned CLK_HZ   = 125_000_000,
    parameter logic [31:0]     FREQ_RST = 32'h0180_0000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              freq_we_i,
    input  logic [FREQ_W-1:0] freq_wdata_i,
    output logic [FREQ_W-1:0] freq_o,
    output logic [CNT_W-1:0]  count_o
);
    localparam int               ACC_W = FREQ_W + 1;
    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(CLK_HZ);

    logic [FREQ_W-1:0] freq_q;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  step;
    logic [ACC_W-1:0]  sum;
    logic [CNT_W-1:0]  count_q;
    logic              running;

    assign running = (freq_q != '0);
    assign step    = ({1'b0, freq_q} > LIMIT) ? LIMIT : {1'b0, freq_q};
    assign sum     = acc_q + step;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            freq_q <= FREQ_W'(FREQ_RST);
        end else if (freq_we_i) begin
            freq_q <= freq_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q   <= '0;
            count_q <= '0;
        end else if (!running) begin
            acc_q   <= '0;
            count_q <= '0;
        end else if (sum >= LIMIT) begin
            acc_q   <= sum - LIMIT;
            count_q <= count_q + 1'b1;
        end else begin
            acc_q   <= sum;
        end
    end

    assign freq_o  = freq_q;
    assign count_o = running ? count_q : '0;

    // R8
    cnt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(freq_q == '0) |-> (count_q == '0));

    // R9
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(freq_q != '0) |->
            ((count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1)));

endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int TVAL_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctrl_we_i,
    input  logic             cmp_we_i,
    input  logic             tval_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             en_o,
    output logic             mask_o,
    output logic             status_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CNT_W-1:0] tval_o,
    output logic             irq_o
);
    localparam int EXT_W = CNT_W - TVAL_W;

    tmr_state_e       state_q;
    tmr_state_e       state_d;
    logic             en_q;
    logic             mask_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] rel_ext;
    logic [CNT_W-1:0] diff;
    logic             reached;

    assign rel_ext = {{EXT_W{wdata_i[TVAL_W-1]}}, wdata_i[TVAL_W-1:0]};
    assign reached = (count_i >= cmp_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q   <= 1'b0;
            mask_q <= 1'b0;
        end else if (ctrl_we_i) begin
            en_q   <= wdata_i[CTRL_EN_BIT];
            mask_q <= wdata_i[CTRL_MASK_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmp_q <= '0;
        end else if (cmp_we_i) begin
            cmp_q <= wdata_i;
        end else if (tval_we_i) begin
            cmp_q <= count_i + rel_ext;
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= TMR_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: arm, expire, rearm, disable
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_OFF:   if (en_q) state_d = reached ? TMR_FIRED : TMR_ARMED;
            TMR_ARMED: if (!en_q) state_d = TMR_OFF;
                       else if (reached) state_d = TMR_FIRED;
            TMR_FIRED: if (!en_q) state_d = TMR_OFF;
                       else if (!reached) state_d = TMR_ARMED;
            default:   state_d = TMR_OFF;
        endcase
    end

    // outputs
    always_comb begin
        diff     = cmp_q - count_i;
        en_o     = en_q;
        mask_o   = mask_q;
        cmp_o    = cmp_q;
        tval_o   = {{EXT_W{1'b0}}, diff[TVAL_W-1:0]};
        status_o = en_q && (state_q == TMR_FIRED);
        irq_o    = status_o && !mask_q;
    end

    // R6
    fired_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == TMR_FIRED) |-> $past(en_q && (count_i >= cmp_q)));

    // R5
    tval_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(tval_we_i && !cmp_we_i) |->
            (cmp_q == $past(count_i) + $past(rel_ext)));

    // R7
    irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(ctrl_we_i && wdata_i[CTRL_MASK_BIT]) |-> !irq_o);

endmodule

// File: rtl/cmp_timer_top.sv
module cmp_timer_top
    import cmp_timer_pkg::*;
#(
    parameter int              CNT_W    = 64,
    parameter int              TVAL_W   = 32,
    parameter int              FREQ_W   = 32,
    parameter longint unsigned CLK_HZ   = 125_000_000,
    parameter logic [31:0]     FREQ_RST = 32'h0180_0000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reg_we_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    logic [FREQ_W-1:0] freq;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  cmp;
    logic [CNT_W-1:0]  tval;
    logic              en;
    logic              mask;
    logic              status;

    cmp_sys_count #(
        .CNT_W    (CNT_W),
        .FREQ_W   (FREQ_W),
        .CLK_HZ   (CLK_HZ),
        .FREQ_RST (FREQ_RST)
    ) u_count (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .freq_we_i    (reg_we_i && (reg_addr_i == ADDR_FREQ)),
        .freq_wdata_i (reg_wdata_i[FREQ_W-1:0]),
        .freq_o       (freq),
        .count_o      (count)
    );

    cmp_timer_core #(
        .CNT_W  (CNT_W),
        .TVAL_W (TVAL_W)
    ) u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ctrl_we_i (reg_we_i && (reg_addr_i == ADDR_CTRL)),
        .cmp_we_i  (reg_we_i && (reg_addr_i == ADDR_CMP)),
        .tval_we_i (reg_we_i && (reg_addr_i == ADDR_TVAL)),
        .wdata_i   (reg_wdata_i),
        .count_i   (count),
        .en_o      (en),
        .mask_o    (mask),
        .status_o  (status),
        .cmp_o     (cmp),
        .tval_o    (tval),
        .irq_o     (irq_o)
    );

    always_comb begin
        unique case (reg_addr_i)
            ADDR_CTRL: reg_rdata_o = {{(CNT_W-3){1'b0}}, status, mask, en};
            ADDR_CMP:  reg_rdata_o = cmp;
            ADDR_TVAL: reg_rdata_o = tval;
            default:   reg_rdata_o = {{(CNT_W-FREQ_W){1'b0}}, freq};
        endcase
    end

    assign count_o = count;

endmodule

// File: tb/cmp_timer_top_test.sv
module cmp_timer_top_test;
    localparam longint unsigned HZ = 125_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [63:0] count;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    cmp_timer_top uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .count_o     (count),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [63:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rd("R1 ctrl", 2'd0, 64'd0);
        rd("R1 cmp", 2'd1, 64'd0);
        rd("R1 freq", 2'd3, 64'h0180_0000);
        check("R1 irq", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_count;
        logic [63:0] a;
        wr(2'd3, 64'd0);
        rd("R10 freq zero", 2'd3, 64'd0);
        check("R8 count off", count, 64'd0);
        wait_neg(5);
        check("R8 count stays off", count, 64'd0);
        wr(2'd3, 64'(HZ));
        rd("R10 freq full", 2'd3, 64'(HZ));
        a = count;
        wait_neg(8);
        check("R9 full rate step", count - a, 64'd8);
        wr(2'd3, 64'(HZ / 4));
        wait_neg(1);
        a = count;
        wait_neg(8);
        check("R9 quarter rate step", count - a, 64'd2);
    endtask

    task automatic t_ctrl;
        wr(2'd3, 64'd0);
        wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        wait_neg(1);
        rd("R2 upper bits ignored", 2'd0, 64'h3);
        wr(2'd0, 64'h4);
        wait_neg(1);
        rd("R2 status write ignored", 2'd0, 64'h0);
    endtask

    task automatic t_views;
        wr(2'd1, 64'h0123_4567_89AB_CDEF);
        rd("R3 cmp readback", 2'd1, 64'h0123_4567_89AB_CDEF);
        wr(2'd1, 64'hFFFF_FFFF_0000_0010);
        rd("R4 tval truncated", 2'd2, 64'h10);
        wr(2'd1, 64'd100);
        rd("R4 tval plain", 2'd2, 64'd100);
        wr(2'd2, 64'hAAAA_AAAA_FFFF_FFFB);
        rd("R5 tval negative", 2'd1, 64'hFFFF_FFFF_FFFF_FFFB);
        wr(2'd2, 64'h5555_5555_0000_0007);
        rd("R5 tval positive", 2'd1, 64'd7);
    endtask

    task automatic t_fire;
        wr(2'd1, 64'd1);
        wr(2'd0, 64'h1);
        wait_neg(2);
        check("R6 below limit irq", {63'd0, irq}, 64'd0);
        rd("R6 below limit status", 2'd0, 64'h1);
        wr(2'd1, 64'd0);
        wait_neg(1);
        check("R6 equal limit irq", {63'd0, irq}, 64'd1);
        rd("R6 equal limit status", 2'd0, 64'h5);
        wr(2'd0, 64'h3);
        check("R7 mask drops irq", {63'd0, irq}, 64'd0);
        rd("R7 status under mask", 2'd0, 64'h7);
        wr(2'd0, 64'h1);
        check("R7 unmask irq", {63'd0, irq}, 64'd1);
        wr(2'd0, 64'h0);
        check("R7 disable drops irq", {63'd0, irq}, 64'd0);
        rd("R6 status when disabled", 2'd0, 64'h0);
        wr(2'd0, 64'h1);
        check("R6 arm latency", {63'd0, irq}, 64'd0);
        wait_neg(1);
        check("R6 arm fired", {63'd0, irq}, 64'd1);
        wr(2'd0, 64'h0);
    endtask

    task automatic t_run;
        wr(2'd3, 64'(HZ));
        wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(2'd0, 64'h1);
        wr(2'd2, 64'd10);
        wait_neg(5);
        check("R5 relative not yet", {63'd0, irq}, 64'd0);
        wait_neg(10);
        check("R5 relative expired", {63'd0, irq}, 64'd1);
        rd("R6 running status", 2'd0, 64'h5);
    endtask

    initial begin
        #(200_000 * 8);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        t_reset();
        t_count();
        t_ctrl();
        t_views();
        t_fire();
        t_run();
        wait_neg(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule